// File: doc/BRIEF.md
# Indexed-Access Interrupt Controller Register Bank

This block is the register front end of an interrupt controller with up to 128 sources. Software never sees a per-source address range. It first writes a source number into a select register. A mode window, a vector window and four one-shot command registers then act on that one source. Per-source storage is the mode (priority and trigger kind), the vector, the enable flag and the pending flag. Each source input raises its pending flag according to its trigger kind. The pending state of all sources can be read at once through four 32-bit banks.

The arbitration core and the nesting stack sit outside this block. The core sees three things: the enabled-and-pending set, the priority of every source and the vector of every source. When the core takes an interrupt, it returns a single acknowledge strobe carrying the source number. The strobe clears that source's pending flag.

The register port is a simple synchronous one. Writes take effect at the clock edge on which `wr_en` is high. Read data is registered.

Top module: `idx_aic_regs`

## Requirements
- R1: After reset, the select register is 0 and every source is disabled and not pending. Every source reads mode 0x40 (priority 0, high-level trigger) and vector equal to its own index. `rdata` is 0.
- R2: Offset 0x00 holds the source select in bits [6:0]. It reads back with all higher bits 0, and upper write bits are dropped.
- R3: The mode window at 0x04 writes and reads the selected source's mode. Priority is bits [2:0] and trigger kind is bits [6:5]. All other bits read 0.
- R4: The vector window at 0x08 writes and reads the selected source's VEC_W-bit vector.
- R5: When the select value is at or above NSRC, the mode and vector windows read 0 and ignore writes. Commands do nothing, and the mask register reads 0.
- R6: Writing a word with bit 0 set to 0x40 enables the selected source, and doing so to 0x44 disables it. A word with bit 0 clear has no effect. Offset 0x30 returns the selected source's enable flag in bit 0.
- R7: Writing a word with bit 0 set to 0x4C sets the selected source's pending flag, and doing so to 0x48 clears it.
- R8: Offsets 0x20, 0x24, 0x28 and 0x2C return pending flags. Bit k of bank b is source 32*b+k. Bits for unimplemented sources read 0.
- R9: Trigger kind 2'b00 pends while the input is low, 2'b01 on a falling edge, 2'b10 while the input is high, and 2'b11 on a rising edge.
- R10: An acknowledge (`ack_valid` with `ack_id`) clears that source's pending flag. A clear command or an acknowledge wins over a trigger event on the same cycle.
- R11: `rdata` is loaded on the edge where `rd_en` is high and holds otherwise. Unmapped offsets (for example 0x10) read 0.
- R12: `active_vec` bit i is high exactly when source i is both enabled and pending. `prio_flat` and `vec_flat` present every source's priority and vector.
- R13: A command write, an acknowledge of another source and trigger events on further sources all take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_in | input | NSRC | Interrupt source lines |
| ack_valid | input | 1 | Acknowledge strobe from the arbitration core |
| ack_id | input | 7 | Source number being acknowledged |
| active_vec | output | NSRC | Enabled-and-pending flags |
| prio_flat | output | 3*NSRC | Priority of each source, 3 bits per source |
| vec_flat | output | VEC_W*NSRC | Vector of each source |

## Verification
Writes and commands land on the edge that samples them, and a read issued in the next cycle returns the new value one edge later. For every read, the bench therefore drives the strobe at a falling edge, removes it at the next falling edge and compares `rdata` there. A source input changed at a falling edge raises its pending flag on the following rising edge, so a bank read issued after one idle cycle already reflects the event. The `active_vec`, `prio_flat` and `vec_flat` outputs follow the state registers with no further delay, and they are compared at the falling edge after the causing write.

// File: rtl/idx_aic_pkg.sv
package idx_aic_pkg;

    localparam int MAX_SRC = 128;
    localparam int SEL_W   = 7;
    localparam int DATA_W  = 32;

    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_VEC  = 8'h08;
    localparam logic [7:0] OFS_MASK = 8'h30;
    localparam logic [7:0] OFS_EN   = 8'h40;
    localparam logic [7:0] OFS_DIS  = 8'h44;
    localparam logic [7:0] OFS_CLR  = 8'h48;
    localparam logic [7:0] OFS_SET  = 8'h4C;

    typedef enum logic [1:0] {
        KIND_LOW  = 2'b00,
        KIND_FALL = 2'b01,
        KIND_HIGH = 2'b10,
        KIND_RISE = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [2:0] prio;
    } mode_t;

    typedef struct packed {
        logic mode_wr;
        logic vec_wr;
        logic en_set;
        logic en_clr;
        logic pd_set;
        logic pd_clr;
    } cmd_t;

    localparam mode_t MODE_RST = '{kind: KIND_HIGH, prio: 3'd0};

    function automatic mode_t word_to_mode(input logic [6:0] w);
        mode_t m;
        m.kind = kind_e'(w[6:5]);
        m.prio = w[2:0];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
        return {25'd0, m.kind, 2'b00, m.prio};
    endfunction

    function automatic logic trig_event(input kind_e k, input logic now, input logic prev);
        logic ev;
        case (k)
            KIND_LOW:  ev = ~now;
            KIND_FALL: ev = prev & ~now;
            KIND_HIGH: ev = now;
            default:   ev = now & ~prev;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/idx_aic_slot.sv
module idx_aic_slot
    import idx_aic_pkg::*;
#(
    parameter int VEC_W = 32,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  cmd_t             cmd,
    input  logic [VEC_W-1:0] vec_wdata,
    input  logic [6:0]       mode_wdata,
    input  logic             src,
    input  logic             ack,
    output mode_t            mode_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             en_q,
    output logic             pend_q
);

    logic prev_q;
    logic set_in;
    logic kill;
    logic pend_nxt;

    always_comb begin
        set_in   = trig_event(mode_q.kind, src, prev_q) | (hit & cmd.pd_set);
        kill     = (hit & cmd.pd_clr) | ack;
        pend_nxt = (pend_q | set_in) & ~kill;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
            vec_q  <= VEC_W'(IDX);
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= src;
            pend_q <= pend_nxt;
            if (hit && cmd.mode_wr) mode_q <= word_to_mode(mode_wdata);
            if (hit && cmd.vec_wr)  vec_q  <= vec_wdata;
            if (hit && cmd.en_set)      en_q <= 1'b1;
            else if (hit && cmd.en_clr) en_q <= 1'b0;
        end
    end

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && cmd.mode_wr) |=> $stable(mode_q));

    // R6
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && (cmd.en_set || cmd.en_clr)) |=> $stable(en_q));

    // R10
    pend_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (ack || (hit && cmd.pd_clr)) |=> !pend_q);

endmodule

// File: rtl/idx_aic_rdmux.sv
module idx_aic_rdmux
    import idx_aic_pkg::*;
(
    input  logic [7:0]         addr,
    input  logic [SEL_W-1:0]   sel,
    input  logic               sel_ok,
    input  logic [DATA_W-1:0]  mode_word,
    input  logic [DATA_W-1:0]  vec_word,
    input  logic               en_bit,
    input  logic [MAX_SRC-1:0] pend_pad,
    output logic [DATA_W-1:0]  rd_word
);

    always_comb begin
        rd_word = '0;
        if (addr[7:4] == 4'h2 && addr[1:0] == 2'b00) begin
            rd_word = pend_pad[{addr[3:2], 5'b00000} +: DATA_W];
        end else begin
            case (addr)
                OFS_SEL:  rd_word = {{(DATA_W-SEL_W){1'b0}}, sel};
                OFS_MODE: rd_word = sel_ok ? mode_word : '0;
                OFS_VEC:  rd_word = sel_ok ? vec_word : '0;
                OFS_MASK: rd_word = {{(DATA_W-1){1'b0}}, sel_ok & en_bit};
                default:  rd_word = '0;
            endcase
        end
    end

endmodule

// File: rtl/idx_aic_regs.sv
module idx_aic_regs
    import idx_aic_pkg::*;
#(
    parameter int NSRC  = 50,
    parameter int VEC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [7:0]              addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    input  logic [NSRC-1:0]         src_in,
    input  logic                    ack_valid,
    input  logic [6:0]              ack_id,
    output logic [NSRC-1:0]         active_vec,
    output logic [NSRC*3-1:0]       prio_flat,
    output logic [NSRC*VEC_W-1:0]   vec_flat
);

    localparam int PAD_W = MAX_SRC - NSRC;

    logic [SEL_W-1:0] sel_q;
    logic             sel_ok;
    cmd_t             cmd;
    logic [NSRC-1:0]  hit_vec;
    logic [NSRC-1:0]  en_vec;
    logic [NSRC-1:0]  pend_vec;
    mode_t            mode_arr [NSRC];
    logic [VEC_W-1:0] vec_arr  [NSRC];

    mode_t              cur_mode;
    logic [VEC_W-1:0]   cur_vec;
    logic               cur_en;
    logic [MAX_SRC-1:0] pend_pad;
    logic [DATA_W-1:0]  rd_word;

    assign sel_ok = ({1'b0, sel_q} < 8'(NSRC));

    always_comb begin
        cmd.mode_wr = wr_en && addr == OFS_MODE;
        cmd.vec_wr  = wr_en && addr == OFS_VEC;
        cmd.en_set  = wr_en && addr == OFS_EN  && wdata[0];
        cmd.en_clr  = wr_en && addr == OFS_DIS && wdata[0];
        cmd.pd_set  = wr_en && addr == OFS_SET && wdata[0];
        cmd.pd_clr  = wr_en && addr == OFS_CLR && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_en && addr == OFS_SEL) begin
            sel_q <= wdata[SEL_W-1:0];
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_slot
        assign hit_vec[i] = sel_ok && (sel_q == SEL_W'(i));

        idx_aic_slot #(.VEC_W(VEC_W), .IDX(i)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .hit        (hit_vec[i]),
            .cmd        (cmd),
            .vec_wdata  (wdata[VEC_W-1:0]),
            .mode_wdata (wdata[6:0]),
            .src        (src_in[i]),
            .ack        (ack_valid && ack_id == SEL_W'(i)),
            .mode_q     (mode_arr[i]),
            .vec_q      (vec_arr[i]),
            .en_q       (en_vec[i]),
            .pend_q     (pend_vec[i])
        );

        assign prio_flat[i*3 +: 3]      = mode_arr[i].prio;
        assign vec_flat[i*VEC_W +: VEC_W] = vec_arr[i];
    end

    assign active_vec = en_vec & pend_vec;

    always_comb begin
        cur_mode = MODE_RST;
        cur_vec  = '0;
        cur_en   = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (hit_vec[i]) begin
                cur_mode = mode_arr[i];
                cur_vec  = vec_arr[i];
                cur_en   = en_vec[i];
            end
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign pend_pad = {{PAD_W{1'b0}}, pend_vec};
        end else begin : g_full
            assign pend_pad = pend_vec;
        end
    endgenerate

    idx_aic_rdmux u_rdmux (
        .addr      (addr),
        .sel       (sel_q),
        .sel_ok    (sel_ok),
        .mode_word (mode_to_word(cur_mode)),
        .vec_word  (DATA_W'(cur_vec)),
        .en_bit    (cur_en),
        .pend_pad  (pend_pad),
        .rd_word   (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OFS_SEL) |=> $stable(sel_q));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R5
    no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_ok |-> hit_vec == '0);

endmodule

// File: tb/sim_idx_aic_regs.sv
module sim_idx_aic_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 50;
    localparam int VEC_W = 32;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  wr_en = 1'b0;
    logic                  rd_en = 1'b0;
    logic [7:0]            addr = '0;
    logic [31:0]           wdata = '0;
    logic [31:0]           rdata;
    logic [NSRC-1:0]       src_in = '0;
    logic                  ack_valid = 1'b0;
    logic [6:0]            ack_id = '0;
    logic [NSRC-1:0]       active_vec;
    logic [NSRC*3-1:0]     prio_flat;
    logic [NSRC*VEC_W-1:0] vec_flat;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_aic_regs #(.NSRC(NSRC), .VEC_W(VEC_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .src_in(src_in), .ack_valid(ack_valid),
        .ack_id(ack_id), .active_vec(active_vec), .prio_flat(prio_flat),
        .vec_flat(vec_flat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [31:0] md(input int i);
        return 32'hFFFF_0000 | 32'(i * 37);
    endfunction

    function automatic logic [31:0] vv(input int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h0103_0507);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_bank [4];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rdata after reset", rdata, 32'h0);
        chk("R1 active after reset", 32'(active_vec != '0), 32'h0);
        rd(8'h00, d); chk("R1 select reset", d, 32'h0);

        // R1, R3, R4, R12 sweep over every implemented source
        for (int i = 0; i < NSRC; i++) begin
            wr(8'h00, 32'(i));
            rd(8'h04, d); chk("R1 mode reset", d, 32'h40);
            rd(8'h08, d); chk("R1 vector reset", d, 32'(i));
            rd(8'h30, d); chk("R1 mask reset", d, 32'h0);
            wr(8'h04, md(i));
            wr(8'h08, vv(i));
            rd(8'h04, d); chk("R3 mode readback", d, md(i) & 32'h67);
            rd(8'h08, d); chk("R4 vector readback", d, vv(i));
            chk("R12 prio_flat", 32'(prio_flat[i*3 +: 3]), md(i) & 32'h7);
            chk("R12 vec_flat", vec_flat[i*VEC_W +: VEC_W], vv(i));
        end

        // R2
        wr(8'h00, 32'hFFFF_FF85);
        rd(8'h00, d); chk("R2 select upper bits dropped", d, 32'h05);

        // R5
        for (int s = 50; s < 128; s += 77) begin
            wr(8'h00, 32'(s));
            wr(8'h04, 32'h27);
            wr(8'h08, 32'h1234_5678);
            wr(8'h40, 32'h1);
            rd(8'h04, d); chk("R5 mode window out of range", d, 32'h0);
            rd(8'h08, d); chk("R5 vector window out of range", d, 32'h0);
            rd(8'h30, d); chk("R5 mask out of range", d, 32'h0);
            chk("R5 enable ignored", 32'(active_vec != '0), 32'h0);
        end
        wr(8'h00, 32'd49);
        rd(8'h04, d); chk("R5 no alias into source 49", d, md(49) & 32'h67);
        rd(8'h08, d); chk("R5 no alias vector 49", d, vv(49));

        // restore high-level mode and clear pending
        for (int i = 0; i < NSRC; i++) begin
            wr(8'h00, 32'(i));
            wr(8'h04, 32'h40);
            wr(8'h48, 32'h1);
        end
        for (int b = 0; b < 4; b++) begin
            rd(8'(8'h20 + 4*b), d); chk("R7 all clear", d, 32'h0);
        end

        // R6
        wr(8'h00, 32'd7);
        wr(8'h40, 32'h2);
        rd(8'h30, d); chk("R6 enable with bit0 clear ignored", d, 32'h0);
        wr(8'h40, 32'h1);
        rd(8'h30, d); chk("R6 enable", d, 32'h1);
        wr(8'h44, 32'hFFFF_FFFE);
        rd(8'h30, d); chk("R6 disable with bit0 clear ignored", d, 32'h1);
        wr(8'h44, 32'h1);
        rd(8'h30, d); chk("R6 disable", d, 32'h0);

        // R7, R8: set every third source, read all banks
        for (int b = 0; b < 4; b++) exp_bank[b] = '0;
        for (int i = 0; i < NSRC; i += 3) begin
            wr(8'h00, 32'(i));
            wr(8'h4C, 32'h1);
            exp_bank[i/32][i%32] = 1'b1;
        end
        for (int b = 0; b < 4; b++) begin
            rd(8'(8'h20 + 4*b), d); chk("R8 pending bank", d, exp_bank[b]);
        end
        for (int i = 0; i < NSRC; i += 3) begin
            wr(8'h00, 32'(i));
            wr(8'h48, 32'h1);
        end
        rd(8'h20, d); chk("R7 clear bank0", d, 32'h0);
        rd(8'h24, d); chk("R7 clear bank1", d, 32'h0);

        // R9 rising edge on source 10
        wr(8'h00, 32'd10); wr(8'h04, 32'h60);
        @(negedge clk); src_in[10] = 1'b1;
        rd(8'h20, d); chk("R9 rising edge pends", d, 32'h400);
        wr(8'h48, 32'h1);
        rd(8'h20, d); chk("R9 rising held high no repend", d, 32'h0);
        // falling edge on source 11
        wr(8'h00, 32'd11); wr(8'h04, 32'h20);
        @(negedge clk); src_in[11] = 1'b1;
        rd(8'h20, d); chk("R9 falling kind ignores rise", d, 32'h0);
        @(negedge clk); src_in[11] = 1'b0;
        rd(8'h20, d); chk("R9 falling edge pends", d, 32'h800);
        wr(8'h48, 32'h1);
        // high level on source 12
        wr(8'h00, 32'd12);
        @(negedge clk); src_in[12] = 1'b1;
        rd(8'h20, d); chk("R9 high level pends", d, 32'h1000);
        wr(8'h48, 32'h1);
        rd(8'h20, d); chk("R9 high level re-pends after clear", d, 32'h1000);
        @(negedge clk); src_in[12] = 1'b0;
        wr(8'h48, 32'h1);
        // low level on source 13
        wr(8'h00, 32'd13); wr(8'h04, 32'h00);
        rd(8'h20, d); chk("R9 low level pends", d, 32'h2000);
        @(negedge clk); src_in[13] = 1'b1;
        wr(8'h48, 32'h1);
        rd(8'h20, d); chk("R9 low level released", d, 32'h0);

        // R10 acknowledge
        wr(8'h00, 32'd20); wr(8'h4C, 32'h1);
        wr(8'h00, 32'd23); wr(8'h4C, 32'h1);
        rd(8'h20, d); chk("R10 set before ack", d, 32'h0090_0000);
        @(negedge clk); ack_valid = 1'b1; ack_id = 7'd20;
        @(negedge clk); ack_valid = 1'b0;
        rd(8'h20, d); chk("R10 ack clears", d, 32'h0080_0000);

        // R13 same-edge: set on 22, ack 23, rise on 24; ack 25 wins over its rise
        wr(8'h00, 32'd24); wr(8'h04, 32'h60);
        wr(8'h00, 32'd25); wr(8'h04, 32'h60);
        wr(8'h00, 32'd22);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h4C; wdata = 32'h1;
        ack_valid = 1'b1; ack_id = 7'd23;
        src_in[24] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ack_valid = 1'b0;
        @(negedge clk);
        ack_valid = 1'b1; ack_id = 7'd25; src_in[25] = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        rd(8'h20, d); chk("R13 same-edge updates", d, 32'h0140_0000);
        chk("R10 ack wins over edge", {31'd0, d[25]}, 32'h0);

        // R12 active vector
        chk("R12 nothing enabled", 32'(active_vec != '0), 32'h0);
        wr(8'h40, 32'h1);
        chk("R12 active source 22", 32'(active_vec), 32'h0040_0000);

        // R11
        rd(8'h10, d); chk("R11 unmapped reads zero", d, 32'h0);
        rd(8'h00, d);
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", rdata, 32'd22);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule